// File: doc/BRIEF.md
# Ethernet PHY Basic Control Register

This block holds the basic control word of an Ethernet PHY as a management-frame engine sees it. The engine presents single-cycle write and read strobes with a 16-bit data word. The block stores the control fields and drives them as levels to the PHY core: loopback, effective speed, effective duplex, power-down, isolation and a restart-negotiation request. It also runs two sequences of its own.

The first sequence is a soft reset. It has a timed busy phase, and writes are dropped during that phase. The second is the auto-negotiation restart handshake with the core. The core reports whether negotiation is supported and when a requested negotiation has started. While negotiation is enabled, the core also supplies the negotiated speed and duplex.

Reads return the word one cycle after the read strobe, together with a one-cycle valid pulse. An asynchronous active-low hardware reset loads the default field values at once and does not run the busy phase.

Top module: `phy_ctrl_reg`

## Requirements
- R1: Word layout, from bit 15 down: bit 15 soft reset, bit 14 loopback, bit 13 speed (1 = 100 Mbps), bit 12 negotiation enable, bit 11 power-down, bit 10 isolate, bit 9 negotiation restart, bit 8 duplex (1 = full), bit 7 collision test. Bits 6:0 always read 0. A read strobe in cycle n puts the word on `rd_data_o`, with `rd_valid_o` high, in cycle n+1.
- R2: After hardware reset the word reads 0x3400: speed 1, negotiation enable 1, isolate 1, all other bits 0. `isolate_o` is 1, and `loopback_o`, `power_down_o` and `aneg_restart_o` are 0.
- R3: An accepted write with bit 15 set starts a soft reset. Bit 15 then reads 1 for exactly RST_CYCLES cycles after the write edge, and after that it reads 0 with no further write.
- R4: Every write that arrives while the soft reset is busy is ignored. No field and no output changes.
- R5: The write that starts a soft reset loads the defaults, and the other bits of that write are discarded. When the busy phase ends the word reads 0x3400.
- R6: While negotiation is enabled, `speed_100_o` and `full_duplex_o` follow `aneg_speed_i` and `aneg_duplex_i`. While it is disabled, they follow the stored speed and duplex bits.
- R7: Bit 9 reads 0 and `aneg_restart_o` is 0 whenever `aneg_supported_i` is 0 or negotiation is disabled. A restart written under those conditions does not remain pending.
- R8: A write with bits 12 and 9 both set, while negotiation is supported, makes a restart pending. Bit 9 then reads 1 and `aneg_restart_o` is high until `aneg_started_i` is sampled. In that cycle `aneg_restart_o` is already 0, and bit 9 reads 0 from the next cycle.
- R9: A write with bit 9 clear does not cancel a pending restart.
- R10: `loopback_o`, `power_down_o` and `isolate_o` follow the stored bits. The word stays writable and readable while isolated or powered down.
- R11: The collision-test bit is stored and read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| wr_data_i | input | 16 | Write data |
| rd_en_i | input | 1 | Single-cycle read strobe |
| rd_data_o | output | 16 | Read data, valid one cycle after the strobe |
| rd_valid_o | output | 1 | Read data valid pulse |
| aneg_supported_i | input | 1 | Core supports auto-negotiation |
| aneg_started_i | input | 1 | Core acknowledges that negotiation has started |
| aneg_speed_i | input | 1 | Negotiated speed (1 = 100 Mbps) |
| aneg_duplex_i | input | 1 | Negotiated duplex (1 = full) |
| loopback_o | output | 1 | Loopback mode |
| speed_100_o | output | 1 | Effective speed |
| full_duplex_o | output | 1 | Effective duplex |
| power_down_o | output | 1 | Power-down mode |
| isolate_o | output | 1 | Isolate data path |
| aneg_restart_o | output | 1 | Restart-negotiation request level |

## Verification
The assertions assume that `aneg_started_i` is a response to a pending request and that `aneg_supported_i` stays still for the length of a restart handshake. The stimulus changes `aneg_supported_i` only when no restart is pending, and it pulses the acknowledge only while the request is high. Strobes are driven clear of the clock edge. The stimulus writes during the soft-reset busy phase and reads on every cycle across its end. This way the exact busy length, and the fact that the write was dropped, are both visible at the read port.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;
  localparam int WORD_W = 16;

  localparam int B_RST  = 15;
  localparam int B_LPBK = 14;
  localparam int B_SPD  = 13;
  localparam int B_ANEN = 12;
  localparam int B_PDN  = 11;
  localparam int B_ISO  = 10;
  localparam int B_RSTR = 9;
  localparam int B_DPX  = 8;
  localparam int B_COL  = 7;

  typedef struct packed {
    logic loopback;
    logic speed;
    logic aneg_en;
    logic power_down;
    logic isolate;
    logic duplex;
    logic col_test;
  } ctl_fields_t;

  localparam ctl_fields_t FIELDS_DEFAULT = '{
    loopback: 1'b0, speed: 1'b1, aneg_en: 1'b1, power_down: 1'b0,
    isolate: 1'b1, duplex: 1'b0, col_test: 1'b0};

  function automatic ctl_fields_t unpack_fields(input logic [WORD_W-1:0] w);
    ctl_fields_t f;
    f.loopback   = w[B_LPBK];
    f.speed      = w[B_SPD];
    f.aneg_en    = w[B_ANEN];
    f.power_down = w[B_PDN];
    f.isolate    = w[B_ISO];
    f.duplex     = w[B_DPX];
    f.col_test   = w[B_COL];
    return f;
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input logic busy,
                                                  input ctl_fields_t f,
                                                  input logic restart);
    logic [WORD_W-1:0] w;
    w         = '0;
    w[B_RST]  = busy;
    w[B_LPBK] = f.loopback;
    w[B_SPD]  = f.speed;
    w[B_ANEN] = f.aneg_en;
    w[B_PDN]  = f.power_down;
    w[B_ISO]  = f.isolate;
    w[B_RSTR] = restart;
    w[B_DPX]  = f.duplex;
    w[B_COL]  = f.col_test;
    return w;
  endfunction
endpackage

// File: rtl/phy_ctrl_rst_seq.sv
module phy_ctrl_rst_seq #(
  parameter int RST_CYCLES = 1_250_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(RST_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;

  p_start_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  p_busy_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> busy_o);
  p_busy_ends_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(cnt_q) == '0);
endmodule

// File: rtl/phy_ctrl_fields.sv
module phy_ctrl_fields
  import phy_ctrl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_default_i,
  input  logic        wr_ok_i,
  input  ctl_fields_t wr_fields_i,
  input  logic        aneg_speed_i,
  input  logic        aneg_duplex_i,
  output ctl_fields_t fields_o,
  output logic        speed_eff_o,
  output logic        duplex_eff_o
);
  ctl_fields_t fields_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             fields_q <= FIELDS_DEFAULT;
    else if (load_default_i) fields_q <= FIELDS_DEFAULT;
    else if (wr_ok_i)        fields_q <= wr_fields_i;
  end

  // negotiation result overrides stored speed/duplex
  always_comb begin
    speed_eff_o  = fields_q.aneg_en ? aneg_speed_i  : fields_q.speed;
    duplex_eff_o = fields_q.aneg_en ? aneg_duplex_i : fields_q.duplex;
  end

  assign fields_o = fields_q;

  p_load_default_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_default_i |=> fields_q == FIELDS_DEFAULT);
  p_write_lands_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok_i && !load_default_i) |=> fields_q == $past(wr_fields_i));
endmodule

// File: rtl/phy_ctrl_aneg_restart.sv
module phy_ctrl_aneg_restart (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic wr_ok_i,
  input  logic wr_restart_i,
  input  logic wr_aneg_en_i,
  input  logic aneg_en_i,
  input  logic supported_i,
  input  logic started_i,
  output logic pend_o,
  output logic req_o
);
  logic pend_q, set_req, en_next;

  always_comb begin
    en_next = wr_ok_i ? wr_aneg_en_i : aneg_en_i;
    set_req = wr_ok_i && wr_restart_i && wr_aneg_en_i && supported_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                pend_q <= 1'b0;
    else if (clear_i)                           pend_q <= 1'b0;
    else if (set_req)                           pend_q <= 1'b1;
    else if (!en_next || !supported_i || started_i) pend_q <= 1'b0;
  end

  always_comb begin
    pend_o = pend_q && aneg_en_i && supported_i;
    req_o  = pend_o && !started_i;
  end

  p_ack_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && started_i && !set_req) |=> !pend_q);
  p_zero_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && wr_ok_i && !wr_restart_i && wr_aneg_en_i && supported_i
     && !started_i && !clear_i) |=> pend_q);
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
  import phy_ctrl_pkg::*;
#(
  parameter int RST_CYCLES = 1_250_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  input  logic        rd_en_i,
  output logic [15:0] rd_data_o,
  output logic        rd_valid_o,
  input  logic        aneg_supported_i,
  input  logic        aneg_started_i,
  input  logic        aneg_speed_i,
  input  logic        aneg_duplex_i,
  output logic        loopback_o,
  output logic        speed_100_o,
  output logic        full_duplex_o,
  output logic        power_down_o,
  output logic        isolate_o,
  output logic        aneg_restart_o
);
  logic        busy, start_rst, wr_ok, restart_rd;
  ctl_fields_t fields, wr_fields;
  logic [WORD_W-1:0] word;
  logic        unused_low;

  assign unused_low = ^wr_data_i[6:0];

  always_comb begin
    start_rst = wr_en_i && !busy && wr_data_i[B_RST];
    wr_ok     = wr_en_i && !busy && !wr_data_i[B_RST];
    wr_fields = unpack_fields(wr_data_i);
  end

  phy_ctrl_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_rst_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_rst),
    .busy_o (busy)
  );

  phy_ctrl_fields u_fields (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_default_i(start_rst),
    .wr_ok_i       (wr_ok),
    .wr_fields_i   (wr_fields),
    .aneg_speed_i  (aneg_speed_i),
    .aneg_duplex_i (aneg_duplex_i),
    .fields_o      (fields),
    .speed_eff_o   (speed_100_o),
    .duplex_eff_o  (full_duplex_o)
  );

  phy_ctrl_aneg_restart u_restart (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (start_rst),
    .wr_ok_i     (wr_ok),
    .wr_restart_i(wr_data_i[B_RSTR]),
    .wr_aneg_en_i(wr_data_i[B_ANEN]),
    .aneg_en_i   (fields.aneg_en),
    .supported_i (aneg_supported_i),
    .started_i   (aneg_started_i),
    .pend_o      (restart_rd),
    .req_o       (aneg_restart_o)
  );

  assign word = pack_word(busy, fields, restart_rd);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= word;
    end
  end

  assign loopback_o   = fields.loopback;
  assign power_down_o = fields.power_down;
  assign isolate_o    = fields.isolate;

  p_low_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> rd_data_o[6:0] == 7'd0);
  p_busy_freeze_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(fields));
  p_reset_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> fields == FIELDS_DEFAULT);
  p_restart_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aneg_restart_o |-> (fields.aneg_en && aneg_supported_i));
  p_no_start_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !start_rst);
endmodule

// File: tb/phy_ctrl_reg_bench.sv
module phy_ctrl_reg_bench;
  localparam int RC = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0;
  logic [15:0] wr_data = '0;
  logic sup = 0, started = 0, an_spd = 0, an_dpx = 0;
  logic [15:0] rd_data;
  logic rd_valid, lb_o, spd_o, dpx_o, pd_o, iso_o, rq_o;

  int vectors = 0, fails = 0, cycles = 0;

  phy_ctrl_reg #(.RST_CYCLES(RC)) u_phy_ctrl_reg (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .aneg_supported_i(sup), .aneg_started_i(started),
    .aneg_speed_i(an_spd), .aneg_duplex_i(an_dpx),
    .loopback_o(lb_o), .speed_100_o(spd_o), .full_duplex_o(dpx_o),
    .power_down_o(pd_o), .isolate_o(iso_o), .aneg_restart_o(rq_o));

  always #5 clk = ~clk;

  // behavioural reference model
  int   m_busy;
  logic m_lb, m_sp, m_an, m_pd, m_iso, m_dx, m_col, m_pend, m_rdv;
  logic [15:0] m_rd;

  function automatic logic [15:0] m_word();
    logic [15:0] w;
    w = '0;
    w[15] = (m_busy > 0); w[14] = m_lb; w[13] = m_sp; w[12] = m_an;
    w[11] = m_pd; w[10] = m_iso; w[9] = m_pend && m_an && sup;
    w[8] = m_dx; w[7] = m_col;
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_lb <= 0; m_sp <= 1; m_an <= 1; m_pd <= 0; m_iso <= 1;
      m_dx <= 0; m_col <= 0; m_pend <= 0; m_rdv <= 0; m_rd <= '0;
    end else begin
      m_rdv <= rd_en;
      if (rd_en) m_rd <= m_word();
      if (m_busy > 0) m_busy <= m_busy - 1;
      else if (wr_en && wr_data[15]) begin
        m_busy <= RC;
        m_lb <= 0; m_sp <= 1; m_an <= 1; m_pd <= 0; m_iso <= 1;
        m_dx <= 0; m_col <= 0; m_pend <= 0;
      end else if (wr_en) begin
        m_lb <= wr_data[14]; m_sp <= wr_data[13]; m_an <= wr_data[12];
        m_pd <= wr_data[11]; m_iso <= wr_data[10]; m_dx <= wr_data[8];
        m_col <= wr_data[7];
        if (wr_data[9] && wr_data[12] && sup) m_pend <= 1;
        else if (!wr_data[12] || !sup || started) m_pend <= 0;
      end else if (!m_an || !sup || started) m_pend <= 0;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk("R10 loopback", {15'd0, lb_o}, {15'd0, m_lb});
    chk("R10 power-down", {15'd0, pd_o}, {15'd0, m_pd});
    chk("R10 isolate", {15'd0, iso_o}, {15'd0, m_iso});
    chk("R6 speed", {15'd0, spd_o}, {15'd0, m_an ? an_spd : m_sp});
    chk("R6 duplex", {15'd0, dpx_o}, {15'd0, m_an ? an_dpx : m_dx});
    chk("R8 request", {15'd0, rq_o}, {15'd0, m_pend && m_an && sup && !started});
    chk("R1 valid", {15'd0, rd_valid}, {15'd0, m_rdv});
    if (m_rdv) chk("R1 read data", rd_data, m_rd);
  end

  task automatic wr(input logic [15:0] d);
    @(posedge clk); #2 wr_en = 1; wr_data = d;
    @(posedge clk); #2 wr_en = 0; wr_data = '0;
  endtask

  task automatic rd(input logic [15:0] exp, input string tag);
    @(posedge clk); #2 rd_en = 1;
    @(posedge clk); #2 rd_en = 0;
    chk(tag, rd_data, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R2 reset state
    chk("R2 isolate", {15'd0, iso_o}, 16'd1);
    chk("R2 loopback/pd/restart", {13'd0, lb_o, pd_o, rq_o}, 16'd0);
    rd(16'h3400, "R2 default word");
    // manual mode, R11 collision test, R6 stored values
    an_spd = 0; an_dpx = 0;
    wr(16'h61FF);
    rd(16'h6180, "R11 col test / R1 low bits zero");
    chk("R6 manual speed", {14'd0, spd_o, dpx_o}, 16'd3);
    // negotiation overrides stored bits
    wr(16'h1100); an_spd = 1; an_dpx = 0;
    #1 chk("R6 negotiated", {14'd0, spd_o, dpx_o}, 16'd2);
    // R7 unsupported / disabled
    sup = 0; wr(16'h1200);
    rd(16'h1000, "R7 unsupported restart reads 0");
    chk("R7 no request", {15'd0, rq_o}, 16'd0);
    sup = 1; wr(16'h0200);
    rd(16'h0000, "R7 disabled restart reads 0");
    wr(16'h1000);
    rd(16'h1000, "R7 nothing left pending");
    // R8 handshake, R9 write zero keeps pending
    wr(16'h1200);
    chk("R8 request high", {15'd0, rq_o}, 16'd1);
    rd(16'h1200, "R8 restart reads 1");
    wr(16'h1000);
    rd(16'h1200, "R9 zero write keeps pending");
    @(posedge clk); #2 started = 1;
    #1 chk("R8 drops with ack", {15'd0, rq_o}, 16'd0);
    @(posedge clk); #2 started = 0;
    rd(16'h1000, "R8 cleared after ack");
    // R10 isolate and power-down stay accessible
    wr(16'h0C00);
    chk("R10 pd+iso", {14'd0, pd_o, iso_o}, 16'd3);
    rd(16'h0C00, "R10 read in isolate");
    wr(16'h4800);
    rd(16'h4800, "R10 write in power-down");
    // R3/R5 soft reset, R4 writes dropped
    wr(16'hC180);
    rd(16'hB400, "R5 reset write discards bits");
    wr(16'h4000);
    chk("R4 loopback unchanged", {15'd0, lb_o}, 16'd0);
    @(posedge clk); #2 rd_en = 1;
    repeat (RC) @(posedge clk);
    #2 rd_en = 0;
    rd(16'h3400, "R3 busy ended / R5 defaults");
    chk("R4 write ignored", {15'd0, lb_o}, 16'd0);
    repeat (3) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    while (cycles < 5000) begin @(posedge clk); cycles++; end
    fails++;
    $display("FAIL watchdog: actual %0d expected <5000 cycles", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule